// File: doc/BRIEF.md
# Compact 24-bit Float Multiply / Min / Max / Compare Unit

This unit evaluates one operation per cycle on two operands held in a narrow custom float format: a sign bit (bit 23), a 7-bit biased exponent (bits 22:16, bias 63) and a 16-bit stored mantissa (bits 15:0) with an implied leading one for normal numbers. An exponent of all ones encodes infinity when the mantissa is zero and NaN otherwise. An exponent of zero with a nonzero mantissa is a subnormal.

The special-value rules follow a deliberate non-IEEE convention. Zero results are always emitted with a clear sign bit. Multiplication treats subnormal operands and results as zero. Infinity times zero gives zero. Min and max keep the first operand only when their strict test holds, so a NaN first operand yields the second operand. Compare and selection work on the raw encoded values and never flush subnormals.

A request is presented with `in_valid`, an operation select and a comparison code. The result appears on the registered outputs one cycle later.

Top module: `f24_alu`

## Requirements
- R1: The operation select uses 0 for multiply, 1 for minimum, 2 for maximum and 3 for compare. A request accepted with `in_valid` high drives `out_valid` high on the next cycle, with its result. A cycle without a request gives `out_valid`, `out_result` and `out_flag` all 0, and reset clears all three.
- R2: No output ever carries negative zero. Every zero result, including a minimum or maximum that selects an operand encoded as 0x800000, is emitted as 0x000000.
- R3: Multiplying two finite normal operands truncates the significand product toward zero. The sign is the XOR of the input signs. An unbiased result exponent at or above 127 gives a correctly signed infinity (exponent 127, mantissa 0). A result exponent at or below 0 gives +0.
- R4: Multiply treats subnormal operands as +0. Infinity times zero (or times a subnormal) gives +0. Infinity times a nonzero finite value gives infinity with the XOR sign.
- R5: Multiply with any NaN operand returns the NaN code 0x7FFFFF, even when the other operand is zero.
- R6: Maximum returns operand A when A > B and operand B otherwise. Minimum returns A when A < B and B otherwise. Any comparison that involves a NaN is false, so max(NaN, 0) = 0 and max(0, NaN) = NaN.
- R7: Minimum, maximum and compare do not flush subnormals. The largest subnormal 0x00FFFF is not equal to 0, and max(0x00FFFF, 0) returns 0x00FFFF.
- R8: The compare code takes 0 for EQ, 1 for NE, 2 for LT, 3 for LE, 4 for GT and 5 for GE, and codes 6 and 7 are always true. NE is true whenever EQ is false, including unordered pairs. Both zero encodings compare equal. For a compare, `out_flag` carries the answer and `out_result` is 0. For every other operation, `out_flag` is 0.
- R9: Starting from 1.0 (0x3F0000) and multiplying repeatedly by 0.5 (0x3E0000), the result first compares equal to zero after exactly 63 multiplies.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request present this cycle |
| op_sel | input | 2 | Operation select |
| cmp_code | input | 3 | Comparison code for compare requests |
| opa | input | 24 | Operand A |
| opb | input | 24 | Operand B |
| out_valid | output | 1 | Result valid, one cycle after the request |
| out_result | output | 24 | Multiply, minimum or maximum result |
| out_flag | output | 1 | Compare outcome |

## Verification
The properties assume that `op_sel`, `cmp_code` and both operands are known whenever `in_valid` is high. They also assume that these inputs hold still around the rising edge, because the checks on the following cycle look back at them with `$past`. The bench changes every input only on the falling clock edge and never leaves one undriven after reset. It sweeps a grid of operands that covers each class: zero of both signs, subnormal, smallest and largest normal, infinity and NaN. Every operand pair is run through each operation and each comparison code.

// File: rtl/f24_pkg.sv
package f24_pkg;

    localparam int unsigned F_EXP_W   = 7;
    localparam int unsigned F_MAN_W   = 16;
    localparam int unsigned F_W       = 1 + F_EXP_W + F_MAN_W;
    localparam int unsigned F_BIAS    = (1 << (F_EXP_W - 1)) - 1;
    localparam int unsigned F_EXP_MAX = (1 << F_EXP_W) - 1;
    localparam int unsigned F_SIG_W   = F_MAN_W + 1;
    localparam int unsigned F_PROD_W  = 2 * F_SIG_W;

    typedef enum logic [1:0] {
        OP_MUL = 2'd0,
        OP_MIN = 2'd1,
        OP_MAX = 2'd2,
        OP_CMP = 2'd3
    } f24_op_e;

    typedef enum logic [2:0] {
        CC_EQ  = 3'd0,
        CC_NE  = 3'd1,
        CC_LT  = 3'd2,
        CC_LE  = 3'd3,
        CC_GT  = 3'd4,
        CC_GE  = 3'd5,
        CC_TR6 = 3'd6,
        CC_TR7 = 3'd7
    } f24_cc_e;

    typedef struct packed {
        logic                 sign;
        logic [F_EXP_W-1:0]   exp;
        logic [F_MAN_W-1:0]   man;
        logic                 is_nan;
        logic                 is_inf;
        logic                 is_zero;
        logic                 is_sub;
    } f24_cls_t;

    typedef struct packed {
        logic             valid;
        logic [F_W-1:0]   result;
        logic             flag;
    } f24_state_t;

    localparam logic [F_W-1:0] F_QNAN = {1'b0, {F_EXP_W{1'b1}}, {F_MAN_W{1'b1}}};

    function automatic logic [F_W-1:0] f24_canon(input logic [F_W-1:0] x);
        return (x[F_W-2:0] == '0) ? '0 : x;
    endfunction

endpackage

// File: rtl/f24_classify.sv
module f24_classify
    import f24_pkg::*;
(
    input  logic [F_W-1:0] val,
    output f24_cls_t       cls
);
    logic exp_ones;
    logic exp_zero;
    logic man_zero;

    always_comb begin
        exp_ones    = (val[F_W-2 -: F_EXP_W] == {F_EXP_W{1'b1}});
        exp_zero    = (val[F_W-2 -: F_EXP_W] == '0);
        man_zero    = (val[F_MAN_W-1:0] == '0);
        cls.sign    = val[F_W-1];
        cls.exp     = val[F_W-2 -: F_EXP_W];
        cls.man     = val[F_MAN_W-1:0];
        cls.is_nan  = exp_ones & ~man_zero;
        cls.is_inf  = exp_ones & man_zero;
        cls.is_zero = exp_zero & man_zero;
        cls.is_sub  = exp_zero & ~man_zero;
    end
endmodule

// File: rtl/f24_mul_core.sv
module f24_mul_core
    import f24_pkg::*;
(
    input  f24_cls_t        a_cls,
    input  f24_cls_t        b_cls,
    output logic [F_W-1:0]  prod
);
    logic                  a_flat;
    logic                  b_flat;
    logic                  sgn;
    logic [F_PROD_W-1:0]   raw;
    logic                  norm;
    logic [F_MAN_W-1:0]    man_res;
    int                    e_sum;

    always_comb begin
        a_flat  = a_cls.is_zero | a_cls.is_sub;
        b_flat  = b_cls.is_zero | b_cls.is_sub;
        sgn     = a_cls.sign ^ b_cls.sign;
        raw     = {{F_SIG_W{1'b0}}, 1'b1, a_cls.man} * {{F_SIG_W{1'b0}}, 1'b1, b_cls.man};
        norm    = raw[F_PROD_W-1];
        man_res = norm ? raw[F_PROD_W-2 -: F_MAN_W] : raw[F_PROD_W-3 -: F_MAN_W];
        e_sum   = int'(a_cls.exp) + int'(b_cls.exp) - int'(F_BIAS) + int'(norm);

        if (a_cls.is_nan || b_cls.is_nan) begin
            prod = F_QNAN;
        end else if ((a_cls.is_inf && b_flat) || (b_cls.is_inf && a_flat)) begin
            prod = '0;
        end else if (a_cls.is_inf || b_cls.is_inf) begin
            prod = {sgn, {F_EXP_W{1'b1}}, {F_MAN_W{1'b0}}};
        end else if (a_flat || b_flat) begin
            prod = '0;
        end else if (e_sum >= int'(F_EXP_MAX)) begin
            prod = {sgn, {F_EXP_W{1'b1}}, {F_MAN_W{1'b0}}};
        end else if (e_sum <= 0) begin
            prod = '0;
        end else begin
            prod = {sgn, e_sum[F_EXP_W-1:0], man_res};
        end
    end
endmodule

// File: rtl/f24_order_core.sv
module f24_order_core
    import f24_pkg::*;
(
    input  f24_cls_t a_cls,
    input  f24_cls_t b_cls,
    output logic     unord,
    output logic     lt,
    output logic     eq
);
    logic signed [F_W-1:0] key_a;
    logic signed [F_W-1:0] key_b;

    always_comb begin
        key_a = $signed({1'b0, a_cls.exp, a_cls.man});
        key_b = $signed({1'b0, b_cls.exp, b_cls.man});
        if (a_cls.sign) key_a = -key_a;
        if (b_cls.sign) key_b = -key_b;
        unord = a_cls.is_nan | b_cls.is_nan;
        lt    = ~unord & (key_a < key_b);
        eq    = ~unord & (key_a == key_b);
    end
endmodule

// File: rtl/f24_alu.sv
module f24_alu
    import f24_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    input  logic [1:0]      op_sel,
    input  logic [2:0]      cmp_code,
    input  logic [23:0]     opa,
    input  logic [23:0]     opb,
    output logic            out_valid,
    output logic [23:0]     out_result,
    output logic            out_flag
);
    localparam int unsigned N_OPND = 2;

    logic [F_W-1:0] opnd [N_OPND];
    f24_cls_t       cls  [N_OPND];

    assign opnd[0] = opa;
    assign opnd[1] = opb;

    for (genvar gi = 0; gi < N_OPND; gi++) begin : g_cls
        f24_classify cls_i (
            .val (opnd[gi]),
            .cls (cls[gi])
        );
    end

    logic [F_W-1:0] mul_res;
    logic           unord;
    logic           lt;
    logic           eq;
    logic           gt;

    f24_mul_core mul_i (
        .a_cls (cls[0]),
        .b_cls (cls[1]),
        .prod  (mul_res)
    );

    f24_order_core ord_i (
        .a_cls (cls[0]),
        .b_cls (cls[1]),
        .unord (unord),
        .lt    (lt),
        .eq    (eq)
    );

    f24_state_t st_d;
    f24_state_t st_q;
    f24_op_e    op_e;
    f24_cc_e    cc_e;

    always_comb begin
        op_e = f24_op_e'(op_sel);
        cc_e = f24_cc_e'(cmp_code);
        gt   = ~unord & ~lt & ~eq;
        st_d = '0;
        st_d.valid = in_valid;
        if (in_valid) begin
            unique case (op_e)
                OP_MUL: st_d.result = mul_res;
                OP_MIN: st_d.result = f24_canon(lt ? opa : opb);
                OP_MAX: st_d.result = f24_canon(gt ? opa : opb);
                OP_CMP: begin
                    unique case (cc_e)
                        CC_EQ:   st_d.flag = eq;
                        CC_NE:   st_d.flag = ~eq;
                        CC_LT:   st_d.flag = lt;
                        CC_LE:   st_d.flag = lt | eq;
                        CC_GT:   st_d.flag = gt;
                        CC_GE:   st_d.flag = gt | eq;
                        default: st_d.flag = 1'b1;
                    endcase
                end
                default: st_d.result = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid  = st_q.valid;
    assign out_result = st_q.result;
    assign out_flag   = st_q.flag;

endmodule

// File: rtl/f24_alu_chk.sv
module f24_alu_chk
    import f24_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        in_valid,
    input logic [1:0]  op_sel,
    input logic [2:0]  cmp_code,
    input logic [23:0] opa,
    input logic [23:0] opb,
    input logic        out_valid,
    input logic [23:0] out_result,
    input logic        out_flag
);
    logic a_nan, b_nan, a_inf, b_inf, a_zero, b_zero;

    always_comb begin
        a_nan  = (opa[22:16] == 7'h7F) && (opa[15:0] != '0);
        b_nan  = (opb[22:16] == 7'h7F) && (opb[15:0] != '0);
        a_inf  = (opa[22:16] == 7'h7F) && (opa[15:0] == '0);
        b_inf  = (opb[22:16] == 7'h7F) && (opb[15:0] == '0);
        a_zero = (opa[22:0] == '0);
        b_zero = (opb[22:0] == '0);
    end

    AST_VALID_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);                                              // R1
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && out_result == '0 && !out_flag));           // R1
    AST_NO_NEG_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_result != 24'h800000));                            // R2
    AST_INF_TIMES_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_sel == 2'd0 && ((a_inf && b_zero) || (b_inf && a_zero)))
        |=> (out_result == '0));                                              // R4
    AST_NAN_MUL: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_sel == 2'd0 && (a_nan || b_nan))
        |=> (out_result == F_QNAN));                                          // R5
    AST_SEL_OPERAND: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (op_sel == 2'd1 || op_sel == 2'd2))
        |=> (out_result == $past(opa) || out_result == $past(opb) || out_result == '0)); // R6
    AST_CODE_TRUE: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_sel == 2'd3 && cmp_code[2:1] == 2'b11) |=> out_flag);   // R8
    AST_FLAG_ONLY_CMP: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_sel != 2'd3) |=> !out_flag);                          // R8

endmodule

bind f24_alu f24_alu_chk chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .op_sel     (op_sel),
    .cmp_code   (cmp_code),
    .opa        (opa),
    .opb        (opb),
    .out_valid  (out_valid),
    .out_result (out_result),
    .out_flag   (out_flag)
);

// File: tb/f24_alu_tb_top.sv
module f24_alu_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [1:0]  op_sel = '0;
    logic [2:0]  cmp_code = '0;
    logic [23:0] opa = '0;
    logic [23:0] opb = '0;
    logic        out_valid;
    logic [23:0] out_result;
    logic        out_flag;

    int n_total = 0;
    int n_bad   = 0;
    bit done    = 1'b0;

    always #2 clk = ~clk;

    f24_alu dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_sel(op_sel),
        .cmp_code(cmp_code), .opa(opa), .opb(opb),
        .out_valid(out_valid), .out_result(out_result), .out_flag(out_flag)
    );

    function automatic real pw2(input int n);
        real r = 1.0;
        if (n >= 0) for (int i = 0; i < n; i++) r = r * 2.0;
        else        for (int i = 0; i < -n; i++) r = r / 2.0;
        return r;
    endfunction

    function automatic bit is_nan(input logic [23:0] x);
        return x[22:16] == 7'h7F && x[15:0] != 0;
    endfunction
    function automatic bit is_inf(input logic [23:0] x);
        return x[22:16] == 7'h7F && x[15:0] == 0;
    endfunction
    function automatic bit is_sub(input logic [23:0] x);
        return x[22:16] == 0 && x[15:0] != 0;
    endfunction

    function automatic real to_real(input logic [23:0] x);
        real v;
        if (is_inf(x))            v = 1.0e300;
        else if (x[22:16] == 0)   v = real'(x[15:0]) * pw2(-78);
        else                      v = (1.0 + real'(x[15:0]) / 65536.0) * pw2(int'(x[22:16]) - 63);
        return x[23] ? -v : v;
    endfunction

    function automatic logic [23:0] ref_mul(input logic [23:0] a, input logic [23:0] b);
        bit   za = (a[22:16] == 0);
        bit   zb = (b[22:16] == 0);
        logic s  = a[23] ^ b[23];
        real  p;
        int   e;
        if (is_nan(a) || is_nan(b))                 return 24'h7FFFFF;
        if ((is_inf(a) && zb) || (is_inf(b) && za)) return 24'h0;
        if (is_inf(a) || is_inf(b))                 return {s, 7'h7F, 16'h0};
        if (za || zb)                               return 24'h0;
        p = (1.0 + real'(a[15:0]) / 65536.0) * (1.0 + real'(b[15:0]) / 65536.0);
        e = int'(a[22:16]) + int'(b[22:16]) - 63;
        while (p >= 2.0) begin p = p / 2.0; e++; end
        if (e >= 127) return {s, 7'h7F, 16'h0};
        if (e <= 0)   return 24'h0;
        return {s, 7'(e), 16'($rtoi((p - 1.0) * 65536.0))};
    endfunction

    function automatic logic [23:0] canon(input logic [23:0] x);
        return (x[22:0] == 0) ? 24'h0 : x;
    endfunction

    task automatic check(input string req, input logic [24:0] act, input logic [24:0] exp);
        n_total++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h (op=%0d cc=%0d a=%h b=%h)",
                     req, act, exp, op_sel, cmp_code, opa, opb);
        end
    endtask

    task automatic issue(input logic [1:0] op, input logic [2:0] cc,
                         input logic [23:0] a, input logic [23:0] b);
        in_valid = 1'b1; op_sel = op; cmp_code = cc; opa = a; opb = b;
        @(negedge clk);
    endtask

    logic [23:0] vals [88];

    initial begin
        int e_tab [11] = '{0, 1, 2, 30, 62, 63, 64, 100, 125, 126, 127};
        logic [15:0] m_tab [4] = '{16'h0000, 16'h0001, 16'h8000, 16'hFFFF};
        int k = 0;
        for (int s = 0; s < 2; s++)
            for (int ei = 0; ei < 11; ei++)
                for (int mi = 0; mi < 4; mi++) begin
                    vals[k] = {1'(s), 7'(e_tab[ei]), m_tab[mi]};
                    k++;
                end

        repeat (3) @(negedge clk);
        check("R1 reset", {out_flag, out_result}, 25'h0);
        check("R1 reset valid", {24'h0, out_valid}, 25'h0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < 88; i++) begin
            for (int j = 0; j < 88; j++) begin
                logic [23:0] a = vals[i];
                logic [23:0] b = vals[j];
                real va = to_real(a);
                real vb = to_real(b);
                bit  un = is_nan(a) || is_nan(b);
                bit  lt = !un && va < vb;
                bit  eq = !un && va == vb;
                bit  gt = !un && va > vb;
                bit  sb = is_sub(a) || is_sub(b);
                logic [23:0] m;

                issue(2'd0, 3'd0, a, b);
                m = ref_mul(a, b);
                if (un)                                   check("R5 mul nan", {out_flag, out_result}, {1'b0, m});
                else if (a[22:16] == 0 || b[22:16] == 0 || is_inf(a) || is_inf(b))
                                                          check("R4 mul special", {out_flag, out_result}, {1'b0, m});
                else                                      check("R3 mul normal", {out_flag, out_result}, {1'b0, m});

                issue(2'd1, 3'd0, a, b);
                check(sb ? "R7 min sub" : "R6 min", {out_flag, out_result}, {1'b0, canon(lt ? a : b)});
                issue(2'd2, 3'd0, a, b);
                check(sb ? "R7 max sub" : "R6 max", {out_flag, out_result}, {1'b0, canon(gt ? a : b)});

                for (int c = 0; c < 8; c++) begin
                    bit f;
                    case (c)
                        0: f = eq;
                        1: f = !eq;
                        2: f = lt;
                        3: f = lt || eq;
                        4: f = gt;
                        5: f = gt || eq;
                        default: f = 1'b1;
                    endcase
                    issue(2'd3, 3'(c), a, b);
                    check(sb ? "R7 cmp sub" : "R8 cmp", {out_flag, out_result}, {f, 24'h0});
                end
            end
        end

        issue(2'd1, 3'd0, 24'h800000, 24'h800000);
        check("R2 neg zero", {out_flag, out_result}, 25'h0);
        issue(2'd3, 3'd0, 24'h00FFFF, 24'h000000);
        check("R7 sub eq zero", {24'h0, out_flag}, 25'h0);
        issue(2'd2, 3'd0, 24'h00FFFF, 24'h000000);
        check("R7 max sub", {1'b0, out_result}, {1'b0, 24'h00FFFF});
        issue(2'd2, 3'd0, 24'h7FFFFF, 24'h000000);
        check("R6 max nan first", {1'b0, out_result}, 25'h0);

        begin
            logic [23:0] x = 24'h3F0000;
            int steps = 0;
            bit hit = 1'b0;
            for (int n = 1; n <= 70 && !hit; n++) begin
                issue(2'd0, 3'd0, x, 24'h3E0000);
                x = out_result;
                issue(2'd3, 3'd0, x, 24'h000000);
                if (out_flag) begin hit = 1'b1; steps = n; end
            end
            check("R9 halving count", 25'(steps), 25'd63);
        end

        in_valid = 1'b0;
        @(negedge clk);
        check("R1 idle", {out_valid, out_flag, out_result[22:0]}, 25'h0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", n_total, n_bad);
        $finish;
    end

    initial begin
        #750000;
        if (!done) begin
            n_total++;
            n_bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", n_total, n_bad);
            $finish;
        end
    end

endmodule